// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block holds an 8-bit up-counting timer and an 8-bit watchdog counter. The two share a single 8-bit prescaler. An owner-select input gives the prescaler to exactly one of them at a time. The owner is advanced once every 2^(ratio+1) of its base ticks, where the ratio comes from a 3-bit field. The other counter advances on every one of its base ticks.

The timer's base tick is chosen by a source-select input. It is either the instruction-cycle tick, which is one pulse every second system clock, or a slow external enable pulse of about 16.384 kHz. That pulse is sampled on the system clock. The watchdog's base tick is always the instruction-cycle tick.

The clearing rules for the prescaler depend on who owns it. A timer write always clears it. A watchdog-clear strobe or a sleep strobe clears it only while the watchdog owns it. A change of owner also clears it. Timer overflow sets a sticky flag, and watchdog wraparound gives a one-cycle timeout pulse. Both are meant to be used by the surrounding core logic.

Top module: `pscl_timer_wdt`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tmr_count` reads 0 and `tmr_ovf` and `wdt_timeout` read 0. The prescaler, the watchdog counter and the instruction-cycle phase are also zero.
- R2: The instruction-cycle tick is high on every second clock, starting with the second rising edge after reset is released. With `cfg_src`=0 and the timer unprescaled, `tmr_count` steps by one every two clocks.
- R3: With `cfg_src`=1, the timer's base tick is `slow_tick`. Each clock in which it is high counts as one base tick.
- R4: With `cfg_owner`=0, the timer gains one count on every 2^(`cfg_ratio`+1)-th base tick after the prescaler was last cleared. The watchdog gains one on every instruction-cycle tick.
- R5: With `cfg_owner`=1, the watchdog gains one on every 2^(`cfg_ratio`+1)-th instruction-cycle tick after the prescaler was last cleared. The timer gains one on every base tick.
- R6: A `tmr_wr` pulse loads `tmr_wr_data` into the count on the next edge and clears the prescaler in the same edge, whoever owns it. The load takes priority over any increment in that cycle.
- R7: A timer step from 0xFF to 0x00 sets `tmr_ovf`. The flag stays set until an `ovf_clr` pulse clears it, and a set in the same cycle wins over the clear.
- R8: With `cfg_owner`=1, a `wdt_clr` pulse or a `sleep_req` pulse clears the prescaler. `wdt_clr` also zeroes the watchdog counter and takes priority over its increment.
- R9: With `cfg_owner`=0, `sleep_req` has no effect. `wdt_clr` zeroes the watchdog counter but leaves the prescaler unchanged.
- R10: When the watchdog steps from 0xFF to 0x00, `wdt_timeout` is high for exactly the following cycle.
- R11: A change of `cfg_owner` between two clocks clears the prescaler at the next edge. No divided tick is produced in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow 16.384 kHz enable pulse, one clock wide |
| cfg_owner | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| cfg_src | input | 1 | Timer base: 0 instruction-cycle tick, 1 slow tick |
| cfg_ratio | input | 3 | Divide select, ratio 2^(value+1) |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wr_data | input | 8 | Value loaded by a timer write |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog-clear instruction strobe |
| sleep_req | input | 1 | Sleep instruction strobe |
| tmr_count | output | 8 | Current timer value |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog wrap pulse |

## Verification
Directed runs first hold each owner and source setting fixed across every ratio value. This separates a wrong divide from a wrong tick source or a wrong owner routing. Strobe-heavy runs then fire sleep and watchdog-clear pulses under both owners. Only the owner-dependent clear rule can make the timer step times match in both cases. Owner toggling, write-at-tick and clear-at-set collisions expose priority mistakes. A long seeded random run mixes all inputs, and each output is compared cycle by cycle with a bench-side reference.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

    typedef enum logic {
        OWN_TIMER = 1'b0,
        OWN_WDOG  = 1'b1
    } owner_e;

    typedef enum logic {
        SRC_CYCLE = 1'b0,
        SRC_SLOW  = 1'b1
    } tsrc_e;

endpackage

// File: rtl/pscl_prescaler.sv
module pscl_prescaler
    import pscl_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int RAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  owner_e           owner,
    input  logic [RAT_W-1:0] ratio,
    input  logic             tmr_base_tick,
    input  logic             wdt_base_tick,
    input  logic             tmr_wr,
    input  logic             wdt_clr,
    input  logic             sleep_req,
    output logic             tmr_tick,
    output logic             wdt_tick
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        owner_e           owner;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [PSC_W-1:0] mask;
    logic             in_tick;
    logic             clr;
    logic             div_tick;

    for (genvar i = 0; i < PSC_W; i++) begin : g_mask
        assign mask[i] = (int'(ratio) >= i);
    end

    always_comb begin
        st_d       = st_q;
        st_d.owner = owner;
        in_tick    = (owner == OWN_WDOG) ? wdt_base_tick : tmr_base_tick;
        clr        = tmr_wr
                   || (owner != st_q.owner)
                   || ((owner == OWN_WDOG) && (wdt_clr || sleep_req));
        div_tick   = in_tick && !clr && ((st_q.cnt & mask) == mask);
        if (clr) begin
            st_d.cnt = '0;
        end else if (in_tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tmr_tick = (owner == OWN_WDOG) ? tmr_base_tick : div_tick;
        wdt_tick = (owner == OWN_WDOG) ? div_tick : wdt_base_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, owner: OWN_TIMER};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pscl_timer.sv
module pscl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (wr) begin
            st_d.cnt = wr_data;
        end else if (tick) begin
            wrap     = (st_q.cnt == {CNT_W{1'b1}});
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.ovf = wrap || (st_q.ovf && !ovf_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

endmodule

// File: rtl/pscl_watchdog.sv
module pscl_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic timeout
);

    typedef struct packed {
        logic [WDT_W-1:0] cnt;
        logic             to;
    } wdt_state_t;

    wdt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.to = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.to  = (st_q.cnt == {WDT_W{1'b1}});
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout = st_q.to;

endmodule

// File: rtl/pscl_timer_wdt.sv
module pscl_timer_wdt
    import pscl_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int WDT_W = 8,
    parameter int PSC_W = 8,
    parameter int RAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             cfg_owner,
    input  logic             cfg_src,
    input  logic [RAT_W-1:0] cfg_ratio,
    input  logic             tmr_wr,
    input  logic [CNT_W-1:0] tmr_wr_data,
    input  logic             ovf_clr,
    input  logic             wdt_clr,
    input  logic             sleep_req,
    output logic [CNT_W-1:0] tmr_count,
    output logic             tmr_ovf,
    output logic             wdt_timeout
);

    typedef struct packed {
        logic phase;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       cyc_tick;
    logic       tmr_base;
    logic       tmr_tick;
    logic       wdt_tick;
    owner_e     owner;
    tsrc_e      src;

    always_comb begin
        st_d.phase = !st_q.phase;
        cyc_tick   = st_q.phase;
        owner      = owner_e'(cfg_owner);
        src        = tsrc_e'(cfg_src);
        tmr_base   = (src == SRC_SLOW) ? slow_tick : cyc_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pscl_prescaler #(.PSC_W(PSC_W), .RAT_W(RAT_W)) psc_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .owner         (owner),
        .ratio         (cfg_ratio),
        .tmr_base_tick (tmr_base),
        .wdt_base_tick (cyc_tick),
        .tmr_wr        (tmr_wr),
        .wdt_clr       (wdt_clr),
        .sleep_req     (sleep_req),
        .tmr_tick      (tmr_tick),
        .wdt_tick      (wdt_tick)
    );

    pscl_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tmr_tick),
        .wr      (tmr_wr),
        .wr_data (tmr_wr_data),
        .ovf_clr (ovf_clr),
        .count   (tmr_count),
        .ovf     (tmr_ovf)
    );

    pscl_watchdog #(.WDT_W(WDT_W)) wdt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (wdt_tick),
        .clr     (wdt_clr),
        .timeout (wdt_timeout)
    );

endmodule

// File: rtl/pscl_timer_wdt_chk.sv
module pscl_timer_wdt_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_wr,
    input logic [CNT_W-1:0] tmr_wr_data,
    input logic             wdt_clr,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] tmr_count,
    input logic             tmr_ovf,
    input logic             wdt_timeout,
    input logic             cyc_tick
);

    a_r2_tick_falls: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_tick |=> !cyc_tick);

    a_r2_tick_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_tick |=> cyc_tick);

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> (tmr_count == $past(tmr_count))
                 || (tmr_count == $past(tmr_count) + 1'b1));

    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> (tmr_count == $past(tmr_wr_data)));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && !ovf_clr) |=> tmr_ovf);

    a_r7_ovf_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_ovf) |-> (tmr_count == '0));

    a_r8_clr_blocks_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_timeout);

    a_r10_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

endmodule

bind pscl_timer_wdt pscl_timer_wdt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_wr      (tmr_wr),
    .tmr_wr_data (tmr_wr_data),
    .wdt_clr     (wdt_clr),
    .ovf_clr     (ovf_clr),
    .tmr_count   (tmr_count),
    .tmr_ovf     (tmr_ovf),
    .wdt_timeout (wdt_timeout),
    .cyc_tick    (cyc_tick)
);

// File: tb/pscl_timer_wdt_tb.sv
`timescale 1ns/1ps
module pscl_timer_wdt_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       cfg_owner = 1'b0;
    logic       cfg_src = 1'b0;
    logic [2:0] cfg_ratio = 3'd0;
    logic       tmr_wr = 1'b0;
    logic [7:0] tmr_wr_data = 8'd0;
    logic       ovf_clr = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       sleep_req = 1'b0;
    logic [7:0] tmr_count;
    logic       tmr_ovf;
    logic       wdt_timeout;

    int n_run = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    // reference state, meaning "after the last rising edge"
    int m_phase, m_psc, m_owner_prev, m_tmr, m_ovf, m_wdt, m_to;

    always #2.5 clk = ~clk;

    pscl_timer_wdt dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .cfg_owner   (cfg_owner),
        .cfg_src     (cfg_src),
        .cfg_ratio   (cfg_ratio),
        .tmr_wr      (tmr_wr),
        .tmr_wr_data (tmr_wr_data),
        .ovf_clr     (ovf_clr),
        .wdt_clr     (wdt_clr),
        .sleep_req   (sleep_req),
        .tmr_count   (tmr_count),
        .tmr_ovf     (tmr_ovf),
        .wdt_timeout (wdt_timeout)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_psc = 0; m_owner_prev = 0;
        m_tmr = 0; m_ovf = 0; m_wdt = 0; m_to = 0;
    endtask

    // next state predicted from the requirements for the inputs now held
    task automatic model_step();
        int cyc, base, inb, clr, divn, div, tt, wt, set;
        cyc  = m_phase;
        base = cfg_src ? int'(slow_tick) : cyc;
        clr  = (tmr_wr || (int'(cfg_owner) != m_owner_prev)
               || (cfg_owner && (wdt_clr || sleep_req))) ? 1 : 0;
        inb  = cfg_owner ? cyc : base;
        divn = 1 << (int'(cfg_ratio) + 1);
        div  = (inb != 0 && clr == 0 && ((m_psc + 1) % divn) == 0) ? 1 : 0;
        if (clr != 0) m_psc = 0;
        else if (inb != 0) m_psc = (m_psc + 1) % 256;
        tt = cfg_owner ? base : div;
        wt = cfg_owner ? div : cyc;
        set = 0;
        if (tmr_wr) m_tmr = int'(tmr_wr_data);
        else if (tt != 0) begin
            if (m_tmr == 255) begin m_tmr = 0; set = 1; end
            else m_tmr = m_tmr + 1;
        end
        m_ovf = (set != 0 || (m_ovf != 0 && !ovf_clr)) ? 1 : 0;
        if (wdt_clr) begin m_wdt = 0; m_to = 0; end
        else if (wt != 0) begin
            m_to  = (m_wdt == 255) ? 1 : 0;
            m_wdt = (m_wdt + 1) % 256;
        end else m_to = 0;
        m_owner_prev = int'(cfg_owner);
        m_phase = 1 - m_phase;
    endtask

    // one clock with the inputs as currently set; strobes are dropped afterwards
    task automatic run1();
        model_step();
        @(negedge clk);
        chk(cur_tag, "tmr_count", int'(tmr_count), m_tmr);
        chk(cur_tag, "tmr_ovf", int'(tmr_ovf), m_ovf);
        chk(cur_tag, "wdt_timeout", int'(wdt_timeout), m_to);
        tmr_wr = 1'b0; ovf_clr = 1'b0; wdt_clr = 1'b0;
        sleep_req = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic write_tmr(logic [7:0] v);
        tmr_wr = 1'b1; tmr_wr_data = v;
        run1();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24601));
        model_reset();
        repeat (4) @(negedge clk);
        // R1: state during reset
        chk("R1", "tmr_count in reset", int'(tmr_count), 0);
        chk("R1", "tmr_ovf in reset", int'(tmr_ovf), 0);
        chk("R1", "wdt_timeout in reset", int'(wdt_timeout), 0);
        rst_n = 1'b1;
        cur_tag = "R1";
        run1();

        // R2: timer unprescaled on the instruction-cycle tick
        cur_tag = "R2"; cfg_owner = 1'b1; cfg_src = 1'b0;
        for (int k = 0; k < 600; k++) run1();

        // R3: slow tick as timer base
        cur_tag = "R3"; cfg_src = 1'b1;
        for (int k = 0; k < 1500; k++) begin
            slow_tick = (k % 7 == 3);
            run1();
        end

        // R4: timer owns the prescaler, every ratio
        cur_tag = "R4"; cfg_owner = 1'b0; cfg_src = 1'b0;
        for (int r = 0; r < 8; r++) begin
            cfg_ratio = 3'(r);
            write_tmr(8'hF0);
            for (int k = 0; k < 700; k++) run1();
        end

        // R5 and R10: watchdog owns the prescaler, wraps reach timeouts
        cur_tag = "R5"; cfg_owner = 1'b1;
        for (int r = 0; r < 3; r++) begin
            cfg_ratio = 3'(r);
            for (int k = 0; k < 2200; k++) run1();
        end
        cur_tag = "R10"; cfg_owner = 1'b0; cfg_ratio = 3'd1;
        for (int k = 0; k < 1600; k++) run1();

        // R6: writes landing on tick cycles and elsewhere
        cur_tag = "R6"; cfg_ratio = 3'd0;
        for (int k = 0; k < 600; k++) begin
            if (k % 5 == 0) begin tmr_wr = 1'b1; tmr_wr_data = 8'(250 + (k % 6)); end
            run1();
        end

        // R7: sticky flag, clear pulses, clear coinciding with a wrap
        cur_tag = "R7"; cfg_owner = 1'b1; cfg_src = 1'b0;
        write_tmr(8'hFE);
        for (int k = 0; k < 900; k++) begin
            if (k % 37 == 11) ovf_clr = 1'b1;
            if (k % 128 == 0) begin tmr_wr = 1'b1; tmr_wr_data = 8'hFC; end
            run1();
        end
        for (int k = 0; k < 300; k++) begin
            ovf_clr = 1'b1;
            run1();
        end

        // R8: watchdog owner, sleep and watchdog-clear strobes
        cur_tag = "R8"; cfg_owner = 1'b1; cfg_ratio = 3'd1;
        for (int k = 0; k < 1500; k++) begin
            if (k % 11 == 5) sleep_req = 1'b1;
            if (k % 301 == 150) wdt_clr = 1'b1;
            run1();
        end

        // R9: timer owner, sleep must leave the prescaler alone
        cur_tag = "R9"; cfg_owner = 1'b0; cfg_ratio = 3'd2;
        for (int k = 0; k < 1500; k++) begin
            if (k % 3 == 1) sleep_req = 1'b1;
            if (k % 97 == 40) wdt_clr = 1'b1;
            run1();
        end

        // R11: owner toggling
        cur_tag = "R11"; cfg_ratio = 3'd0;
        for (int k = 0; k < 1200; k++) begin
            if (k % 9 == 0) cfg_owner = ~cfg_owner;
            run1();
        end

        // seeded random mix over all inputs
        cur_tag = "R4";
        for (int k = 0; k < 40000; k++) begin
            if ($urandom_range(255) == 0) cfg_owner = 1'($urandom);
            if ($urandom_range(255) == 0) cfg_src   = 1'($urandom);
            if ($urandom_range(255) == 0) cfg_ratio = 3'($urandom_range(3));
            slow_tick = ($urandom_range(4) == 0);
            if ($urandom_range(63) == 0) begin tmr_wr = 1'b1; tmr_wr_data = 8'($urandom); end
            ovf_clr   = ($urandom_range(31) == 0);
            wdt_clr   = ($urandom_range(200) == 0);
            sleep_req = ($urandom_range(31) == 0);
            run1();
        end

        finish_run();
    end

endmodule